// File: doc/BRIEF.md
# Fixed-Point Load/Store Effective Address Generator

This unit computes the memory address for fixed-point load and store operations from a decoded instruction's operands. A request carries four things: the address form, the update and store flags, the register numbers, and the register values with the raw 16-bit immediate field. The unit first chooses a base term. It then adds either a sign-extended, scaled immediate or a second register value to that base. The sum is presented one clock later together with a valid strobe.

For update forms the unit also decides whether the base register is to be overwritten with the new address. It drives a writeback enable, the target register number and the address as writeback data. Encodings that the update rules forbid raise an invalid-form flag and suppress the writeback, in the same cycle that the address is presented. The address is still formed and shown for such encodings.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and directly after it, out_valid, wb_en and bad_form are 0 and ea is 0.
- R2: Results appear on the clock edge after the one that samples req_valid high, with out_valid high for exactly that cycle. A cycle without a request drives out_valid, wb_en and bad_form to 0 and leaves ea and wb_reg unchanged.
- R3: With form code 0 (displacement), the offset is the 16-bit imm field sign-extended to 64 bits.
- R4: With form code 1 (DS), the offset is imm[15:2] followed by two zero bits, sign-extended. imm[1:0] are ignored and the offset is a multiple of 4.
- R5: With form code 2 (DQ), the offset is imm[15:4] followed by four zero bits, sign-extended. imm[3:0] are ignored and the offset is a multiple of 16.
- R6: With form code 3 (indexed), the offset is rb_val and imm is ignored.
- R7: In a non-update request (upd=0), the base is 0 when ra_num is 0 and ra_val otherwise.
- R8: In an update request (upd=1), the base is always ra_val, even when ra_num is 0.
- R9: The sum base + offset wraps modulo 2^64.
- R10: A load-update request (upd=1, is_store=0) with ra_num=0 or ra_num=rt_num raises bad_form and keeps wb_en low.
- R11: A store-update request (upd=1, is_store=1) is invalid only when ra_num=0. When ra_num equals rt_num the request is valid and wb_en is raised.
- R12: For a valid update request, wb_en=1, wb_reg=ra_num and wb_data=ea. For a non-update request, wb_en=0 and bad_form=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| form | input | 2 | Address form: 0 displacement, 1 DS, 2 DQ, 3 indexed |
| upd | input | 1 | Update form: base register receives the address |
| is_store | input | 1 | 1 for store, 0 for load |
| ra_num | input | 5 | Base register number |
| rt_num | input | 5 | Target (load) or source (store) register number |
| ra_val | input | 64 | Contents of the base register |
| rb_val | input | 64 | Contents of the index register |
| imm | input | 16 | Raw immediate field |
| out_valid | output | 1 | Result strobe |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Write the address back to the base register |
| wb_reg | output | 5 | Register number for the writeback |
| wb_data | output | 64 | Writeback data (the address) |
| bad_form | output | 1 | Invalid update encoding |

## Verification
The hardest case to reach is register number 0 used as the base with a nonzero value on ra_val. Under R7 the value must be discarded in a non-update request, while under R8 it must be added in an update request. A store-update with ra_num equal to rt_num is just as hard to reach, since it is valid even though the same pattern is invalid for a load. The sweep crosses every form, both flags and register numbers that include 0, equal pairs and the top register. ra_val is never zero during the sweep, so a base wrongly chosen as zero or as the register value changes the address. Directed requests add a carry out of bit 63 and an idle cycle that must hold the previous address.

// File: rtl/ea_gen_pkg.sv
// Package: shared form codes for the effective address generator.
// Assumes a 2-bit form selector; code values are part of the interface.
package ea_gen_pkg;

    typedef enum logic [1:0] {
        FORM_D  = 2'd0,
        FORM_DS = 2'd1,
        FORM_DQ = 2'd2,
        FORM_X  = 2'd3
    } ea_form_e;

    // Number of immediate-based forms (D, DS, DQ) built by the offset unit.
    localparam int NUM_IMM_FORMS = 3;

    // Low zero bits appended for each immediate-based form.
    function automatic int imm_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ea_offset.sv
// Module: ea_offset
// Forms the addend from the raw immediate or the index register value.
// Assumes the scaled fields sit at the top of the immediate and their
// low bits are not part of the offset.
module ea_offset
    import ea_gen_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input  logic [1:0]      form,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0] rb_val,
    output logic [XLEN-1:0] offset
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] cand [NUM_IMM_FORMS];

    // One sign-extended candidate per immediate form, each with its own scale.
    for (genvar g = 0; g < NUM_IMM_FORMS; g++) begin : g_imm
        localparam int SH = imm_shift(g);
        logic [IMM_W-1:0] scaled;
        if (SH == 0) begin : g_noscale
            assign scaled = imm;
        end else begin : g_scale
            assign scaled = {imm[IMM_W-1:SH], {SH{1'b0}}};
        end
        assign cand[g] = {{EXT_W{scaled[IMM_W-1]}}, scaled};
    end

    // Choose the addend selected by the form code.
    always_comb begin
        case (ea_form_e'(form))
            FORM_D:  offset = cand[0];
            FORM_DS: offset = cand[1];
            FORM_DQ: offset = cand[2];
            default: offset = rb_val;
        endcase
    end

endmodule

// File: rtl/ea_base_add.sv
// Module: ea_base_add
// Picks the base term and adds the offset, wrapping modulo 2^XLEN.
// Assumes register number 0 reads as literal zero only in non-update forms.
module ea_base_add #(
    parameter int XLEN  = 64,
    parameter int REG_W = 5
) (
    input  logic             upd,
    input  logic [REG_W-1:0] ra_num,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  offset,
    output logic [XLEN-1:0]  sum
);
    logic [XLEN-1:0] base;

    // Base selection: update forms always use the register contents.
    always_comb begin
        if (!upd && (ra_num == '0)) base = '0;
        else                        base = ra_val;
    end

    // Address sum; the carry out of the top bit is dropped.
    always_comb sum = base + offset;

endmodule

// File: rtl/ea_upd_check.sv
// Module: ea_upd_check
// Decides base writeback and flags forbidden update encodings.
// Assumes loads may not target the base register, stores may.
module ea_upd_check #(
    parameter int REG_W = 5
) (
    input  logic             upd,
    input  logic             is_store,
    input  logic [REG_W-1:0] ra_num,
    input  logic [REG_W-1:0] rt_num,
    output logic             wb_ok,
    output logic             bad
);
    logic ra_zero;
    logic ra_eq_rt;

    // Operand comparisons shared by both rules.
    always_comb begin
        ra_zero  = (ra_num == '0);
        ra_eq_rt = (ra_num == rt_num);
    end

    // Validity rule per direction, then writeback only for valid updates.
    always_comb begin
        if (!upd)          bad = 1'b0;
        else if (is_store) bad = ra_zero;
        else               bad = ra_zero || ra_eq_rt;
        wb_ok = upd && !bad;
    end

endmodule

// File: rtl/ea_gen.sv
// Module: ea_gen (top)
// Effective address generator for fixed-point loads and stores with a
// single registered output stage. Assumes one request per cycle at most;
// the address is held between requests.
module ea_gen #(
    parameter int XLEN  = 64,
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       form,
    input  logic             upd,
    input  logic             is_store,
    input  logic [REG_W-1:0] ra_num,
    input  logic [REG_W-1:0] rt_num,
    input  logic [XLEN-1:0]  ra_val,
    input  logic [XLEN-1:0]  rb_val,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [XLEN-1:0]  ea,
    output logic             wb_en,
    output logic [REG_W-1:0] wb_reg,
    output logic [XLEN-1:0]  wb_data,
    output logic             bad_form
);
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;
    logic            wb_ok;
    logic            bad;

    ea_offset #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
        .form   (form),
        .imm    (imm),
        .rb_val (rb_val),
        .offset (offset)
    );

    ea_base_add #(.XLEN(XLEN), .REG_W(REG_W)) u_add (
        .upd    (upd),
        .ra_num (ra_num),
        .ra_val (ra_val),
        .offset (offset),
        .sum    (sum)
    );

    ea_upd_check #(.REG_W(REG_W)) u_chk (
        .upd      (upd),
        .is_store (is_store),
        .ra_num   (ra_num),
        .rt_num   (rt_num),
        .wb_ok    (wb_ok),
        .bad      (bad)
    );

    // Output stage: strobes follow the request, address and target are held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ea        <= '0;
            wb_en     <= 1'b0;
            wb_reg    <= '0;
            bad_form  <= 1'b0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid && wb_ok;
            bad_form  <= req_valid && bad;
            if (req_valid) begin
                ea     <= sum;
                wb_reg <= ra_num;
            end
        end
    end

    // Writeback data is the presented address.
    assign wb_data = ea;

endmodule

// File: rtl/ea_gen_chk.sv
// Module: ea_gen_chk
// Temporal checks on the generator's ports, attached by bind.
module ea_gen_chk #(
    parameter int XLEN  = 64,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       form,
    input logic             upd,
    input logic             is_store,
    input logic [REG_W-1:0] ra_num,
    input logic [REG_W-1:0] rt_num,
    input logic [XLEN-1:0]  ra_val,
    input logic             out_valid,
    input logic [XLEN-1:0]  ea,
    input logic             wb_en,
    input logic [REG_W-1:0] wb_reg,
    input logic             bad_form
);
    // R2
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !wb_en && !bad_form && $stable(ea)));

    // R4
    ds_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd && form == 2'd1) |=> (ea[1:0] == $past(ra_val[1:0])));

    // R5
    dq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd && form == 2'd2) |=> (ea[3:0] == $past(ra_val[3:0])));

    // R10
    load_upd_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd && !is_store && (ra_num == '0 || ra_num == rt_num))
        |=> (bad_form && !wb_en));

    // R11
    store_upd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && upd && is_store && ra_num != '0)
        |=> (wb_en && !bad_form && wb_reg == $past(ra_num)));

    // R12
    no_upd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !upd) |=> (!wb_en && !bad_form));

    // R12
    wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (out_valid && !bad_form));

endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_ea_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .form      (form),
    .upd       (upd),
    .is_store  (is_store),
    .ra_num    (ra_num),
    .rt_num    (rt_num),
    .ra_val    (ra_val),
    .out_valid (out_valid),
    .ea        (ea),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .bad_form  (bad_form)
);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  form = 2'd0;
    logic        upd = 1'b0;
    logic        is_store = 1'b0;
    logic [4:0]  ra_num = '0;
    logic [4:0]  rt_num = '0;
    logic [63:0] ra_val = '0;
    logic [63:0] rb_val = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [63:0] ea;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [63:0] wb_data;
    logic        bad_form;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .form(form),
        .upd(upd), .is_store(is_store), .ra_num(ra_num), .rt_num(rt_num),
        .ra_val(ra_val), .rb_val(rb_val), .imm(imm), .out_valid(out_valid),
        .ea(ea), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .bad_form(bad_form)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected address from the requirements, computed arithmetically.
    function automatic logic [63:0] exp_ea(input logic [1:0] f, input logic u,
            input logic [4:0] ra, input logic [63:0] rav, input logic [63:0] rbv,
            input logic [15:0] im);
        longint base;
        longint off;
        logic signed [15:0] d16;
        logic signed [13:0] d14;
        logic signed [11:0] d12;
        base = (u || ra != 5'd0) ? longint'(rav) : 64'sd0;
        d16 = im;
        d14 = im[15:2];
        d12 = im[15:4];
        case (f)
            2'd0: off = longint'(d16);
            2'd1: off = longint'(d14) * 4;
            2'd2: off = longint'(d12) * 16;
            default: off = longint'(rbv);
        endcase
        return 64'(base + off);
    endfunction

    // Issue one request and check the result one cycle later.
    task automatic issue(input logic [1:0] f, input logic u, input logic st,
            input logic [4:0] ra, input logic [4:0] rt, input logic [63:0] rav,
            input logic [63:0] rbv, input logic [15:0] im, input string tag);
        logic inv;
        logic wexp;
        @(negedge clk);
        req_valid = 1'b1; form = f; upd = u; is_store = st;
        ra_num = ra; rt_num = rt; ra_val = rav; rb_val = rbv; imm = im;
        @(negedge clk);
        req_valid = 1'b0;
        inv  = u && (ra == 5'd0 || (!st && ra == rt));
        wexp = u && !inv;
        chk({tag, " ea"}, ea, exp_ea(f, u, ra, rav, rbv, im));
        chk("R2 out_valid", 64'(out_valid), 64'd1);
        chk(st ? "R11 bad_form" : "R10 bad_form", 64'(bad_form), 64'(inv));
        chk("R12 wb_en", 64'(wb_en), 64'(wexp));
        if (wexp) begin
            chk("R12 wb_reg", 64'(wb_reg), 64'(ra));
            chk("R12 wb_data", wb_data, ea);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [4:0]  regs [4];
        logic [15:0] imms [5];
        string       tags [4];
        logic [63:0] held;
        int k;
        regs[0] = 5'd0; regs[1] = 5'd1; regs[2] = 5'd5; regs[3] = 5'd31;
        imms[0] = 16'h0000; imms[1] = 16'h7FFF; imms[2] = 16'h8000;
        imms[3] = 16'hFFFF; imms[4] = 16'h1235;
        tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 ea", ea, 64'd0);
        chk("R1 wb_en", 64'(wb_en), 64'd0);
        chk("R1 bad_form", 64'(bad_form), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after release", 64'(out_valid), 64'd0);

        // Sweep of forms, flags, register numbers and immediates.
        k = 0;
        for (int f = 0; f < 4; f++)
            for (int u = 0; u < 2; u++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a < 4; a++)
                        for (int t = 0; t < 4; t++)
                            for (int i = 0; i < 5; i++) begin
                                k++;
                                issue(2'(f), u[0], s[0], regs[a], regs[t],
                                      64'h8000_0000_0000_0040 ^ (64'(k) * 64'h0123_4567_89AB_CDEF),
                                      64'h0000_0001_0000_0300 + 64'(k) * 64'h10_0001,
                                      imms[i], u[0] ? "R8" : tags[f]);
                            end

        // R7: register 0 without update ignores its value.
        issue(2'd0, 1'b0, 1'b0, 5'd0, 5'd3, 64'hFFFF_0000_1234_5678, 64'd0, 16'h0010, "R7");
        chk("R7 zero base", ea, 64'h10);
        // R8: register 0 with update uses its value.
        issue(2'd0, 1'b1, 1'b0, 5'd0, 5'd3, 64'h0000_0000_0000_1000, 64'd0, 16'h0010, "R8");
        chk("R8 reg base", ea, 64'h1010);
        // R9: wrap through bit 63.
        issue(2'd3, 1'b0, 1'b0, 5'd4, 5'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0000, "R9");
        chk("R9 wrap", ea, 64'h10);
        issue(2'd0, 1'b1, 1'b1, 5'd7, 5'd7, 64'h0000_0000_0000_0005, 64'd0, 16'hFFF0, "R9");
        chk("R9 negative offset", ea, 64'hFFFF_FFFF_FFFF_FFF5);
        // R11: store-update with base equal to source is valid.
        chk("R11 same reg wb_en", 64'(wb_en), 64'd1);
        chk("R11 same reg wb_reg", 64'(wb_reg), 64'd7);
        // R4/R5: low immediate bits ignored.
        issue(2'd1, 1'b0, 1'b0, 5'd2, 5'd3, 64'h100, 64'd0, 16'h0007, "R4");
        chk("R4 low bits ignored", ea, 64'h104);
        issue(2'd2, 1'b0, 1'b0, 5'd2, 5'd3, 64'h100, 64'd0, 16'h001F, "R5");
        chk("R5 low bits ignored", ea, 64'h110);
        // R6: imm ignored in indexed form.
        issue(2'd3, 1'b0, 1'b0, 5'd2, 5'd3, 64'h100, 64'h23, 16'hFFFF, "R6");
        chk("R6 imm ignored", ea, 64'h123);
        // R10: load-update with base equal to target.
        issue(2'd0, 1'b1, 1'b0, 5'd9, 5'd9, 64'h100, 64'd0, 16'h0004, "R10");
        chk("R10 bad_form", 64'(bad_form), 64'd1);
        chk("R10 wb_en", 64'(wb_en), 64'd0);
        // R2: idle cycle holds the address and clears the strobes.
        held = ea;
        @(negedge clk);
        chk("R2 idle out_valid", 64'(out_valid), 64'd0);
        chk("R2 idle bad_form", 64'(bad_form), 64'd0);
        chk("R2 idle ea held", ea, held);
        chk("R2 idle wb_reg held", 64'(wb_reg), 64'd9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule